// File: doc/BRIEF.md
# Serial Port Register File with Frame Queues

This block is the processor-facing half of a synchronous serial port. A simple word-addressed register bus reaches six registers: a frame-format word, a mode word, a data port, a status word, a clock prescaler and a combined interrupt identify/clear word. Writing the data port queues a frame for transmission and reading it removes the oldest received frame. Two queues of 8 frames (16 bits each) sit between the bus and the serial engine.

The serial engine is attached through two valid/ready streams. On the transmit stream the block presents the head frame with `eng_tx_valid` and holds both valid and data steady until the engine raises `eng_tx_ready`; a frame leaves the queue on every cycle where both are high. On the receive stream the block raises `eng_rx_ready` whenever the port is enabled and never applies back-pressure: a frame offered while the receive queue is full is taken and discarded, and this sets a sticky overrun condition. The frame-format word, the prescaler and the mode bits are driven to the engine as plain configuration pins, and three maskable interrupt sources (receive, transmit, overrun) are combined into one request line.

Top module: `serport_regblk`

## Requirements
- R1: After reset every stored register is zero, the port is disabled, status reads 0x0003, both streams are idle and all interrupt outputs are low.
- R2: The register index is bus_addr[4:2] (the two low address bits are ignored): 0x00 frame format (16 bits), 0x04 mode (7 bits: bit0 receive irq enable, bit1 transmit irq enable, bit2 overrun irq enable, bit3 loopback, bit4 port enable, bit5 slave select, bit6 slave output disable), 0x10 prescaler (8 bits, upper bits read zero); each reads back what was written and drives its configuration pins; offsets 0x18 and 0x1C read zero.
- R3: A write to 0x08 queues a frame; the transmit stream presents queued frames in write order and holds valid and data stable until accepted.
- R4: With 8 frames queued a further data write is ignored and the queue keeps its 8 frames.
- R5: While enabled, frames accepted on the receive stream are returned by reads of 0x08 in arrival order.
- R6: A read of 0x08 with an empty receive queue returns zero and changes no state.
- R7: A frame offered while the receive queue holds 8 frames is discarded and sets the overrun flag.
- R8: Any write to 0x14 clears the overrun flag; if a new overrun happens in the same cycle the flag stays set.
- R9: Interrupt sources are: receive when the receive queue holds at least 4 frames, transmit when the transmit queue holds at most 4 frames, overrun when the flag is set; each is ANDed with its mode enable bit, reads of 0x14 return them at bits 0 (receive), 1 (transmit), 2 (overrun), and `irq` is their OR.
- R10: Writing the mode word with bit4 clear empties both queues in that same cycle and clears the overrun flag; while disabled the transmit stream is idle and receive frames are refused.
- R11: Status at 0x0C is bit0 transmit queue empty, bit1 transmit queue not full, bit2 receive queue not empty, bit3 receive queue full, bit4 busy, where busy is `eng_busy` OR a non-empty transmit queue.
- R12: A bus pop and an engine push of the receive queue in one cycle both take effect, as do a bus push and an engine pop of the transmit queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the access |
| eng_tx_valid | output | 1 | Transmit frame available |
| eng_tx_ready | input | 1 | Engine takes the transmit frame |
| eng_tx_data | output | 16 | Head transmit frame |
| eng_rx_valid | input | 1 | Engine offers a received frame |
| eng_rx_ready | output | 1 | Receive frames accepted (port enabled) |
| eng_rx_data | input | 16 | Received frame |
| eng_busy | input | 1 | Engine is shifting a frame |
| cfg_frame | output | 16 | Frame format word |
| cfg_prescale | output | 8 | Clock prescaler |
| cfg_loopback | output | 1 | Loopback mode |
| cfg_enable | output | 1 | Port enable |
| cfg_slave | output | 1 | Slave mode select |
| cfg_slave_od | output | 1 | Slave output disable |
| irq_rx | output | 1 | Masked receive interrupt |
| irq_tx | output | 1 | Masked transmit interrupt |
| irq_ovr | output | 1 | Masked overrun interrupt |
| irq | output | 1 | OR of the three interrupts |

## Verification
Two pairs of functions can meet in one cycle: a clearing write to 0x14 with a new overrun, and a bus access of a queue with an engine access of the same queue. The bench drives a clear write together with a frame offered to a full receive queue and judges that the identify register still shows the overrun afterwards. It also pops the receive queue from the bus while the engine pushes, and writes the transmit queue while the engine pops, then drains both queues and judges that the order and the number of frames match the expected sequence.

// File: rtl/serport_pkg.sv
package serport_pkg;

  // Register index = byte address / 4
  typedef enum logic [2:0] {
    REG_FRAME = 3'd0,
    REG_MODE  = 3'd1,
    REG_DATA  = 3'd2,
    REG_STAT  = 3'd3,
    REG_PRESC = 3'd4,
    REG_INTID = 3'd5
  } reg_idx_e;

  // Mode word, packed MSB first so rx_ie lands on bit 0
  typedef struct packed {
    logic slave_od;
    logic slave;
    logic enable;
    logic loopback;
    logic ovr_ie;
    logic tx_ie;
    logic rx_ie;
  } mode_t;

  typedef struct packed {
    logic busy;
    logic rx_full;
    logic rx_nempty;
    logic tx_nfull;
    logic tx_empty;
  } stat_t;

  typedef struct packed {
    logic ovr;
    logic tx;
    logic rx;
  } intid_t;

endpackage

// File: rtl/serport_fifo.sv
module serport_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/serport_irq.sv
module serport_irq #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             ovr_set,
  input  logic             ovr_clr,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             rx_ie,
  input  logic             tx_ie,
  input  logic             ovr_ie,
  output logic             irq_rx,
  output logic             irq_tx,
  output logic             irq_ovr,
  output logic             ovr_flag
);
  localparam int HALF = DEPTH / 2;

  // Sticky overrun: flush beats set, set beats clear
  always_ff @(posedge clk) begin
    if (!rst_n || flush)  ovr_flag <= 1'b0;
    else if (ovr_set)     ovr_flag <= 1'b1;
    else if (ovr_clr)     ovr_flag <= 1'b0;
  end

  assign irq_rx  = rx_ie && (rx_cnt >= CNT_W'(HALF));
  assign irq_tx  = tx_ie && (tx_cnt <= CNT_W'(HALF));
  assign irq_ovr = ovr_ie && ovr_flag;
endmodule

// File: rtl/serport_regblk.sv
module serport_regblk
  import serport_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 5,
  parameter int PRESC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               eng_tx_valid,
  input  logic               eng_tx_ready,
  output logic [DATA_W-1:0]  eng_tx_data,
  input  logic               eng_rx_valid,
  output logic               eng_rx_ready,
  input  logic [DATA_W-1:0]  eng_rx_data,
  input  logic               eng_busy,
  output logic [DATA_W-1:0]  cfg_frame,
  output logic [PRESC_W-1:0] cfg_prescale,
  output logic               cfg_loopback,
  output logic               cfg_enable,
  output logic               cfg_slave,
  output logic               cfg_slave_od,
  output logic               irq_rx,
  output logic               irq_tx,
  output logic               irq_ovr,
  output logic               irq
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int MODE_W = $bits(mode_t);

  logic [IDX_W-1:0]   idx;
  logic               wr_stb, rd_stb;
  logic [DATA_W-1:0]  frame_q;
  logic [PRESC_W-1:0] presc_q;
  mode_t              mode_q, mode_wr;
  logic               flush;

  logic               tx_push, tx_pop, tx_empty, tx_full;
  logic [CNT_W-1:0]   tx_cnt;
  logic               rx_push, rx_pop, rx_empty, rx_full, rx_take;
  logic [CNT_W-1:0]   rx_cnt;
  logic [DATA_W-1:0]  rx_head;
  logic               ovr_set, ovr_clr, ovr_flag;
  stat_t              stat;
  intid_t             intid;

  function automatic logic hit(input logic [IDX_W-1:0] i, input reg_idx_e r);
    return i == IDX_W'(r);
  endfunction

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr_stb  = bus_sel && bus_we;
  assign rd_stb  = bus_sel && !bus_we;
  assign mode_wr = mode_t'(bus_wdata[MODE_W-1:0]);

  // Disabling the port empties the queues at the edge of the write itself
  assign flush = !mode_q.enable || (wr_stb && hit(idx, REG_MODE) && !mode_wr.enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      presc_q <= '0;
      mode_q  <= '0;
    end else if (wr_stb) begin
      if (hit(idx, REG_FRAME)) frame_q <= bus_wdata;
      if (hit(idx, REG_MODE))  mode_q  <= mode_wr;
      if (hit(idx, REG_PRESC)) presc_q <= bus_wdata[PRESC_W-1:0];
    end
  end

  // Transmit queue: bus pushes, engine pops
  assign tx_push = wr_stb && hit(idx, REG_DATA);
  assign tx_pop  = eng_tx_valid && eng_tx_ready;

  serport_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (tx_push),
    .pop   (tx_pop),
    .wdata (bus_wdata),
    .rdata (eng_tx_data),
    .count (tx_cnt),
    .empty (tx_empty),
    .full  (tx_full)
  );

  assign eng_tx_valid = mode_q.enable && !tx_empty;

  // Receive queue: engine pushes, bus pops
  assign eng_rx_ready = mode_q.enable;
  assign rx_take      = eng_rx_valid && eng_rx_ready;
  assign rx_push      = rx_take && !rx_full;
  assign ovr_set      = rx_take && rx_full;
  assign rx_pop       = rd_stb && hit(idx, REG_DATA);

  serport_fifo #(.W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (rx_push),
    .pop   (rx_pop),
    .wdata (eng_rx_data),
    .rdata (rx_head),
    .count (rx_cnt),
    .empty (rx_empty),
    .full  (rx_full)
  );

  assign ovr_clr = wr_stb && hit(idx, REG_INTID);

  serport_irq #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .ovr_set  (ovr_set),
    .ovr_clr  (ovr_clr),
    .tx_cnt   (tx_cnt),
    .rx_cnt   (rx_cnt),
    .rx_ie    (mode_q.rx_ie),
    .tx_ie    (mode_q.tx_ie),
    .ovr_ie   (mode_q.ovr_ie),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx),
    .irq_ovr  (irq_ovr),
    .ovr_flag (ovr_flag)
  );

  assign irq = irq_rx || irq_tx || irq_ovr;

  always_comb begin
    stat.busy      = eng_busy || !tx_empty;
    stat.rx_full   = rx_full;
    stat.rx_nempty = !rx_empty;
    stat.tx_nfull  = !tx_full;
    stat.tx_empty  = tx_empty;
    intid.ovr      = irq_ovr;
    intid.tx       = irq_tx;
    intid.rx       = irq_rx;
  end

  always_comb begin
    bus_rdata = '0;
    if      (hit(idx, REG_FRAME)) bus_rdata = frame_q;
    else if (hit(idx, REG_MODE))  bus_rdata = DATA_W'(mode_q);
    else if (hit(idx, REG_DATA))  bus_rdata = rx_empty ? '0 : rx_head;
    else if (hit(idx, REG_STAT))  bus_rdata = DATA_W'(stat);
    else if (hit(idx, REG_PRESC)) bus_rdata = DATA_W'(presc_q);
    else if (hit(idx, REG_INTID)) bus_rdata = DATA_W'(intid);
  end

  assign cfg_frame    = frame_q;
  assign cfg_prescale = presc_q;
  assign cfg_loopback = mode_q.loopback;
  assign cfg_enable   = mode_q.enable;
  assign cfg_slave    = mode_q.slave;
  assign cfg_slave_od = mode_q.slave_od;
endmodule

// File: rtl/serport_chk.sv
module serport_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              cfg_enable,
  input logic              eng_tx_valid,
  input logic              eng_tx_ready,
  input logic [DATA_W-1:0] eng_tx_data,
  input logic              eng_rx_valid,
  input logic              irq_rx,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              ovr_flag
);
  logic clr_hit, rx_full_hit;
  assign clr_hit     = bus_sel && bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(5));
  assign rx_full_hit = cfg_enable && eng_rx_valid && (rx_cnt == CNT_W'(DEPTH));

  // R3: a stalled transmit frame stays put
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_tx_valid && !eng_tx_ready) |=> (!cfg_enable || (eng_tx_valid && $stable(eng_tx_data))));

  // R4: queues never exceed their depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));

  // R7: offering to a full receive queue raises overrun
  p_ovr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full_hit |=> (ovr_flag || !cfg_enable));

  // R8: overrun is sticky until a clear write
  p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_hit) |=> (ovr_flag || !cfg_enable));

  // R8: a clear write without a competing overrun clears the flag
  p_ovr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !rx_full_hit) |=> !ovr_flag);

  // R9: receive interrupt only with at least half the queue filled
  p_rx_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rx_cnt >= CNT_W'(DEPTH / 2)));

  // R10: a disabled port holds empty queues and no overrun
  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && $past(!cfg_enable)) |-> (tx_cnt == '0 && rx_cnt == '0 && !ovr_flag));
endmodule

bind serport_regblk serport_chk #(
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_sel      (bus_sel),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .cfg_enable   (cfg_enable),
  .eng_tx_valid (eng_tx_valid),
  .eng_tx_ready (eng_tx_ready),
  .eng_tx_data  (eng_tx_data),
  .eng_rx_valid (eng_rx_valid),
  .irq_rx       (irq_rx),
  .tx_cnt       (tx_cnt),
  .rx_cnt       (rx_cnt),
  .ovr_flag     (ovr_flag)
);

// File: tb/serport_regblk_bench.sv
module serport_regblk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        eng_tx_valid, eng_tx_ready = 1'b0;
  logic [15:0] eng_tx_data;
  logic        eng_rx_valid = 1'b0, eng_rx_ready;
  logic [15:0] eng_rx_data = '0;
  logic        eng_busy = 1'b0;
  logic [15:0] cfg_frame;
  logic [7:0]  cfg_prescale;
  logic        cfg_loopback, cfg_enable, cfg_slave, cfg_slave_od;
  logic        irq_rx, irq_tx, irq_ovr, irq;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  serport_regblk u_serport_regblk (.*);

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_RX = 2'd2, OP_TP = 2'd3;
  // {req, op, addr, data, expected}
  localparam int NV = 22;
  localparam logic [45:0] VEC [NV] = '{
    {4'd2,  OP_WR, 8'h04, 16'h0010, 16'h0000},  // R2 enable port
    {4'd2,  OP_RD, 8'h04, 16'h0000, 16'h0010},
    {4'd2,  OP_WR, 8'h00, 16'h1C7F, 16'h0000},
    {4'd2,  OP_RD, 8'h00, 16'h0000, 16'h1C7F},
    {4'd2,  OP_WR, 8'h10, 16'hABFE, 16'h0000},
    {4'd2,  OP_RD, 8'h10, 16'h0000, 16'h00FE},  // R2 upper prescaler bits zero
    {4'd11, OP_RD, 8'h0C, 16'h0000, 16'h0003},  // R11 idle status
    {4'd3,  OP_WR, 8'h08, 16'h1111, 16'h0000},
    {4'd3,  OP_WR, 8'h08, 16'h2222, 16'h0000},
    {4'd11, OP_RD, 8'h0C, 16'h0000, 16'h0012},  // R11 busy from queued frames
    {4'd3,  OP_TP, 8'h00, 16'h0000, 16'h1111},  // R3 order
    {4'd3,  OP_TP, 8'h00, 16'h0000, 16'h2222},
    {4'd11, OP_RD, 8'h0C, 16'h0000, 16'h0003},
    {4'd5,  OP_RX, 8'h00, 16'hA5A5, 16'h0000},
    {4'd5,  OP_RX, 8'h00, 16'h5A5A, 16'h0000},
    {4'd5,  OP_RD, 8'h0C, 16'h0000, 16'h0007},  // R5 receive not empty
    {4'd5,  OP_RD, 8'h08, 16'h0000, 16'hA5A5},
    {4'd5,  OP_RD, 8'h08, 16'h0000, 16'h5A5A},
    {4'd6,  OP_RD, 8'h08, 16'h0000, 16'h0000},  // R6 empty read gives zero
    {4'd6,  OP_RD, 8'h0C, 16'h0000, 16'h0003},  // R6 state unchanged
    {4'd2,  OP_RD, 8'h18, 16'h0000, 16'h0000},  // R2 unmapped
    {4'd2,  OP_RD, 8'h06, 16'h0000, 16'h0010}   // R2 low address bits ignored
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // One bus/engine cycle: drive after the falling edge, sample before the rising edge
  task automatic cyc(input logic sel, input logic we, input logic [7:0] a, input logic [15:0] wd,
                     input logic rxv, input logic [15:0] rxd, input logic txr,
                     output logic [15:0] rd, output logic tv, output logic [15:0] td);
    @(negedge clk);
    bus_sel = sel; bus_we = we; bus_addr = a[4:0]; bus_wdata = wd;
    eng_rx_valid = rxv; eng_rx_data = rxd; eng_tx_ready = txr;
    #3;
    rd = bus_rdata; tv = eng_tx_valid; td = eng_tx_data;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0; eng_rx_valid = 1'b0; eng_tx_ready = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] r, t; logic v;
    cyc(1'b1, 1'b1, a, d, 1'b0, 16'h0, 1'b0, r, v, t);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] r);
    logic [15:0] t; logic v;
    cyc(1'b1, 1'b0, a, 16'h0, 1'b0, 16'h0, 1'b0, r, v, t);
  endtask

  task automatic rxp(input logic [15:0] d);
    logic [15:0] r, t; logic v;
    cyc(1'b0, 1'b0, 8'h0, 16'h0, 1'b1, d, 1'b0, r, v, t);
  endtask

  task automatic txpop(output logic v, output logic [15:0] t);
    logic [15:0] r;
    cyc(1'b0, 1'b0, 8'h0, 16'h0, 1'b0, 16'h0, 1'b1, r, v, t);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] r, t;
    logic v;

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, r); chk("R1 mode", r, 16'h0000);
    rd(8'h00, r); chk("R1 frame", r, 16'h0000);
    rd(8'h0C, r); chk("R1 status", r, 16'h0003);
    rd(8'h14, r); chk("R1 intid", r, 16'h0000);
    chk("R1 pins", {eng_tx_valid, eng_rx_ready, irq, cfg_enable}, 4'b0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0]  vq;  logic [1:0] vo;
      logic [7:0]  va;  logic [15:0] vd, ve;
      {vq, vo, va, vd, ve} = VEC[i];
      case (vo)
        OP_WR: wr(va, vd);
        OP_RD: begin rd(va, r); chk($sformatf("R%0d vec%0d", vq, i), r, ve); end
        OP_RX: rxp(vd);
        default: begin
          txpop(v, t);
          chk($sformatf("R%0d vec%0d", vq, i), {v, t}, {1'b1, ve});
        end
      endcase
    end
    chk("R2 cfg pins", {cfg_frame, cfg_prescale, cfg_enable}, {16'h1C7F, 8'hFE, 1'b1});

    // R2 mode bits drive pins
    wr(8'h04, 16'h0078);
    chk("R2 mode pins", {cfg_loopback, cfg_enable, cfg_slave, cfg_slave_od}, 4'b1111);
    rd(8'h04, r); chk("R2 mode readback", r, 16'h0078);
    wr(8'h04, 16'h0010);
    chk("R9 masked irq", irq, 1'b0);

    // R4 transmit full
    for (int i = 0; i < 9; i++) wr(8'h08, 16'h0100 + 16'(i));
    rd(8'h0C, r); chk("R4 status full", r, 16'h0010);
    for (int i = 0; i < 8; i++) begin
      txpop(v, t); chk("R4 drain", {v, t}, {1'b1, 16'h0100 + 16'(i)});
    end
    txpop(v, t); chk("R4 ninth dropped", v, 1'b0);

    // R9 interrupts
    wr(8'h04, 16'h0017);
    rd(8'h14, r); chk("R9 tx irq empty", r, 16'h0002);
    for (int i = 0; i < 3; i++) rxp(16'hC000 + 16'(i));
    rd(8'h14, r); chk("R9 rx below half", r, 16'h0002);
    rxp(16'hC003);
    rd(8'h14, r); chk("R9 rx half", r, 16'h0003);
    for (int i = 0; i < 5; i++) wr(8'h08, 16'h0700 + 16'(i));
    rd(8'h14, r); chk("R9 tx above half", r, 16'h0001);
    for (int i = 4; i < 8; i++) rxp(16'hC000 + 16'(i));
    rd(8'h14, r); chk("R7 full no overrun", r, 16'h0001);
    rxp(16'hDEAD);
    rd(8'h14, r); chk("R7 overrun", r, 16'h0005);
    rd(8'h0C, r); chk("R11 status full", r, 16'h001E);
    chk("R9 irq pin", {irq, irq_ovr}, 2'b11);

    // R8 clear and overrun in the same cycle: set wins
    cyc(1'b1, 1'b1, 8'h14, 16'h0000, 1'b1, 16'hBEEF, 1'b0, r, v, t);
    rd(8'h14, r); chk("R8 set wins", r, 16'h0005);
    wr(8'h14, 16'h1234);
    rd(8'h14, r); chk("R8 cleared", r, 16'h0001);

    // R7 dropped frames never appear
    for (int i = 0; i < 8; i++) begin
      rd(8'h08, r); chk("R7 rx order", r, 16'hC000 + 16'(i));
    end
    rd(8'h08, r); chk("R7 drop", r, 16'h0000);
    rd(8'h14, r); chk("R9 all low", r, 16'h0000);

    // R12 same-cycle bus pop and engine push on receive queue
    rxp(16'h0E01); rxp(16'h0E02);
    cyc(1'b1, 1'b0, 8'h08, 16'h0, 1'b1, 16'h0E03, 1'b0, r, v, t);
    chk("R12 rx pop", r, 16'h0E01);
    rd(8'h08, r); chk("R12 rx2", r, 16'h0E02);
    rd(8'h08, r); chk("R12 rx3", r, 16'h0E03);
    rd(8'h08, r); chk("R12 rx empty", r, 16'h0000);

    // R12 same-cycle bus push and engine pop on transmit queue
    cyc(1'b1, 1'b1, 8'h08, 16'h0777, 1'b0, 16'h0, 1'b1, r, v, t);
    chk("R12 tx pop", {v, t}, {1'b1, 16'h0700});
    for (int i = 1; i < 5; i++) begin
      txpop(v, t); chk("R12 tx order", {v, t}, {1'b1, 16'h0700 + 16'(i)});
    end
    txpop(v, t); chk("R12 tx pushed", {v, t}, {1'b1, 16'h0777});
    txpop(v, t); chk("R12 tx empty", v, 1'b0);

    // R10 disable flushes
    wr(8'h08, 16'h0A01); wr(8'h08, 16'h0A02);
    for (int i = 0; i < 9; i++) rxp(16'h0B00 + 16'(i));
    chk("R10 ready enabled", eng_rx_ready, 1'b1);
    wr(8'h04, 16'h0007);
    rd(8'h14, r); chk("R10 intid after disable", r, 16'h0002);
    rd(8'h0C, r); chk("R10 status after disable", r, 16'h0003);
    chk("R10 streams idle", {eng_tx_valid, eng_rx_ready}, 2'b00);
    rxp(16'h0BAD);
    wr(8'h04, 16'h0017);
    rd(8'h0C, r); chk("R10 refused while disabled", r, 16'h0003);

    // R11 busy from the engine
    eng_busy = 1'b1;
    rd(8'h0C, r); chk("R11 engine busy", r, 16'h0013);
    eng_busy = 1'b0;

    summary();
    $finish;
  end
endmodule